// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial core of an SPI master. Software-side logic pushes right-justified words into an internal transmit queue, sets a static configuration word and pulses `start`. The engine then lowers slave select, runs the serial clock and shifts frames MSB first on `mosi`. Frames it receives are stored right-justified in an internal receive queue, which the host drains through `rx_pop`. When the transfer ends, the engine raises slave select again and returns to idle.

The configuration sets the frame length, clock phase, clock polarity, clock divider, loopback and one of four transfer modes. Two modes run until the transmit queue is empty: full duplex and send-only. Receive-only mode clocks a fixed number of frames and repeats one word on `mosi`. The fourth mode suits serial memories: it first sends every queued word as a command, then clocks a fixed number of frames with `mosi` low and keeps only the data that returns.

Top module: `spi_xfer_engine`

## Requirements
- R1: The frame length is `cfg_frame_size`+1 bits (1 to 16). Each frame is sent MSB first, and only the low `cfg_frame_size`+1 bits of a queued word go out on `mosi`.
- R2: A received frame is stored with its last sampled bit in bit 0 of `rx_data`. All bits above the frame length are zero.
- R3: With `cfg_cpha`=0, `mosi` is valid from the start of the frame and is sampled on the first (leading) clock edge of each bit. With `cfg_cpha`=1, `mosi` changes on the leading edge and is sampled on the trailing edge. Each frame begins with one idle half period of the serial clock.
- R4: Whenever `busy` is low, `sclk` equals `cfg_cpol`. Between frames, `sclk` also returns to that level.
- R5: Each half period of `sclk` lasts `cfg_div`/2 system clocks. `cfg_div` must be even and at least 2.
- R6: Mode 2'b00 (full duplex) sends one queued word per frame until the transmit queue is empty, and pushes every received frame into the receive queue.
- R7: Mode 2'b01 (send-only) sends the queued words like R6 but never writes to the receive queue.
- R8: Mode 2'b10 (receive-only) takes one word from the transmit queue at start. It sends that word in each of `cfg_frames`+1 frames and stores every received frame.
- R9: Mode 2'b11 (command then read) sends all queued words without storing anything. It then runs `cfg_frames`+1 frames with `mosi` low and stores each of them.
- R10: With `cfg_loop`=1, the receive shifter takes its input from the engine's own `mosi` and ignores `miso`. With `cfg_loop`=0, it takes its input from `miso`.
- R11: After reset, `ss_n` is high, `busy` is low and the receive queue is empty. `ss_n` stays low and `busy` stays high for the whole transfer, and a `start` pulse during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_size | input | 4 | Frame length minus one |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_mode | input | 2 | Transfer mode (00 duplex, 01 send-only, 10 receive-only, 11 command-then-read) |
| cfg_loop | input | 1 | Internal loopback of mosi into the receive shifter |
| cfg_div | input | 8 | Even system-clock divider for sclk |
| cfg_frames | input | 8 | Read frame count minus one (modes 10 and 11) |
| start | input | 1 | Pulse that begins a transfer |
| busy | output | 1 | Transfer in progress |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 16 | Right-justified transmit word |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with its default parameters: 16-bit words, queues 8 deep, an 8-bit divider and an 8-bit frame count. With these values, every frame length from a single bit up to the full word can be tried. Dividers from 2 to 10 keep each transfer to a few hundred cycles. Queue depth 8 holds the command-plus-read and multi-word sequences without overflow. A bench-side monitor rebuilds each frame from `mosi` at the edges that R3 names and times the gaps between `sclk` edges. This lets phase, polarity, divider and bit order be checked without looking inside the design.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'b00,
    MODE_SEND    = 2'b01,
    MODE_RECEIVE = 2'b10,
    MODE_CMDREAD = 2'b11
  } xfer_mode_e;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign rdata = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 16,
  parameter int FS_W   = $clog2(DATA_W),
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] word,
  input  logic [FS_W-1:0]   fsize,
  input  logic              cpha,
  input  logic              cpol,
  input  logic [DIV_W-1:0]  div,
  input  logic              loop,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int HC_W = FS_W + 1;

  function automatic logic [DIV_W-1:0] half_ticks(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] h;
    h = d >> 1;
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  function automatic logic [DATA_W-1:0] to_msb(input logic [DATA_W-1:0] w,
                                               input logic [FS_W-1:0]   fs);
    return w << (DATA_W - 1 - int'(fs));
  endfunction

  logic              active, lvl, mosi_q, done_q;
  logic [DIV_W-1:0]  dcnt;
  logic [HC_W-1:0]   hcnt;
  logic [DATA_W-1:0] tsh, rsh, aligned;
  logic              tick, lead_edge, trail_edge, last_half, samp, din;

  assign aligned    = to_msb(word, fsize);
  assign tick       = active && (dcnt == half_ticks(div) - 1'b1);
  assign last_half  = (hcnt == {fsize, 1'b1});
  assign lead_edge  = tick && !hcnt[0];
  assign trail_edge = tick && hcnt[0];
  assign samp       = cpha ? trail_edge : lead_edge;
  assign din        = loop ? mosi_q : miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lvl    <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      dcnt   <= '0;
      hcnt   <= '0;
      tsh    <= '0;
      rsh    <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        active <= 1'b1;
        lvl    <= 1'b0;
        dcnt   <= '0;
        hcnt   <= '0;
        rsh    <= '0;
        if (!cpha) begin
          mosi_q <= aligned[DATA_W-1];
          tsh    <= aligned << 1;
        end else begin
          tsh    <= aligned;
        end
      end else if (active) begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) begin
          lvl  <= ~lvl;
          hcnt <= hcnt + 1'b1;
          if (samp) rsh <= {rsh[DATA_W-2:0], din};
          if ((lead_edge && cpha) || (trail_edge && !cpha && !last_half)) begin
            mosi_q <= tsh[DATA_W-1];
            tsh    <= tsh << 1;
          end
          if (last_half) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk    = cpol ^ lvl;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_word = rsh;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_mode_e        mode,
  input  logic [CNT_W-1:0]  frames,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_head,
  input  logic              frame_done,
  output logic              tx_pop,
  output logic              frame_go,
  output logic              cap_push,
  output logic [DATA_W-1:0] frame_word,
  output logic              busy
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} st_e;

  st_e               st;
  logic [DATA_W-1:0] hold;
  logic [CNT_W:0]    cnt;
  logic              ee_rx, cap, want_cap, from_fifo, fin, load_hold, cnt_done;

  assign cnt_done = (cnt == ({1'b0, frames} + 1'b1));

  always_comb begin
    frame_go   = 1'b0;
    from_fifo  = 1'b0;
    frame_word = '0;
    want_cap   = 1'b0;
    fin        = 1'b0;
    if (st == S_LOAD) begin
      case (mode)
        MODE_DUPLEX, MODE_SEND: begin
          if (tx_empty) fin = 1'b1;
          else begin
            frame_go   = 1'b1;
            from_fifo  = 1'b1;
            frame_word = tx_head;
            want_cap   = (mode == MODE_DUPLEX);
          end
        end
        MODE_RECEIVE: begin
          if (cnt_done) fin = 1'b1;
          else begin
            frame_go   = 1'b1;
            frame_word = hold;
            want_cap   = 1'b1;
          end
        end
        default: begin
          if (!ee_rx && !tx_empty) begin
            frame_go   = 1'b1;
            from_fifo  = 1'b1;
            frame_word = tx_head;
          end else if (cnt_done) fin = 1'b1;
          else begin
            frame_go = 1'b1;
            want_cap = 1'b1;
          end
        end
      endcase
    end
  end

  assign load_hold = (st == S_IDLE) && start && (mode == MODE_RECEIVE) && !tx_empty;
  assign tx_pop    = from_fifo | load_hold;
  assign cap_push  = (st == S_RUN) && frame_done && cap;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hold  <= '0;
      cnt   <= '0;
      ee_rx <= 1'b0;
      cap   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_LOAD;
          cnt   <= '0;
          ee_rx <= 1'b0;
          if (load_hold) hold <= tx_head;
        end
        S_LOAD: begin
          if (fin) st <= S_IDLE;
          else begin
            st  <= S_RUN;
            cap <= want_cap;
            if (want_cap) cnt <= cnt + 1'b1;
            if (!from_fifo) ee_rx <= 1'b1;
          end
        end
        S_RUN: if (frame_done) st <= S_LOAD;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FS_W   = $clog2(DATA_W),
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FS_W-1:0]   cfg_frame_size,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_loop,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_frames,
  input  logic              start,
  output logic              busy,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              sclk,
  output logic              ss_n,
  output logic              mosi,
  input  logic              miso
);
  logic              tx_empty, rx_full, cap_push;
  logic [DATA_W-1:0] tx_head, frame_word;
  logic              evt_tx_pop, evt_rx_push, evt_frame_go, evt_frame_done;
  logic [DATA_W-1:0] evt_rx_word;

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(evt_tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(evt_rx_push), .wdata(evt_rx_word),
    .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty));

  spi_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(xfer_mode_e'(cfg_mode)),
    .frames(cfg_frames), .tx_empty(tx_empty), .tx_head(tx_head),
    .frame_done(evt_frame_done), .tx_pop(evt_tx_pop), .frame_go(evt_frame_go),
    .cap_push(cap_push), .frame_word(frame_word), .busy(busy));

  spi_shift #(.DATA_W(DATA_W), .FS_W(FS_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(evt_frame_go), .word(frame_word),
    .fsize(cfg_frame_size), .cpha(cfg_cpha), .cpol(cfg_cpol), .div(cfg_div),
    .loop(cfg_loop), .miso(miso), .sclk(sclk), .mosi(mosi),
    .done(evt_frame_done), .rx_word(evt_rx_word));

  assign evt_rx_push = cap_push && !rx_full;
  assign ss_n        = !busy;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int DATA_W = 16,
  parameter int FS_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cpol,
  input logic [1:0]        cfg_mode,
  input logic [FS_W-1:0]   cfg_frame_size,
  input logic              sclk,
  input logic              ss_n,
  input logic              busy,
  input logic              tx_empty,
  input logic              evt_tx_pop,
  input logic              evt_rx_push,
  input logic [DATA_W-1:0] evt_rx_word,
  input logic              evt_frame_go,
  input logic              evt_frame_done
);
  logic [DATA_W-1:0] keep_mask;
  always_comb keep_mask = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(cfg_frame_size));

  AST_SCLK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol)); // R4
  AST_SEND_ONLY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_mode == 2'b01) |-> !evt_rx_push); // R7
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_push |-> ((evt_rx_word & ~keep_mask) == '0)); // R2
  AST_NO_TX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_pop |-> !tx_empty); // R6
  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done |=> !ss_n); // R11
  AST_FRAME_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_go |=> !evt_frame_go); // R1
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DATA_W(DATA_W), .FS_W(FS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_mode(cfg_mode),
  .cfg_frame_size(cfg_frame_size), .sclk(sclk), .ss_n(ss_n), .busy(busy),
  .tx_empty(tx_empty), .evt_tx_pop(evt_tx_pop), .evt_rx_push(evt_rx_push),
  .evt_rx_word(evt_rx_word), .evt_frame_go(evt_frame_go),
  .evt_frame_done(evt_frame_done));

// File: tb/sim_spi_xfer_engine.sv
`timescale 1ns/1ps
module sim_spi_xfer_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_frame_size = '0;
  logic cfg_cpha = 0, cfg_cpol = 0, cfg_loop = 0, start = 0, tx_push = 0, rx_pop = 0, miso = 0;
  logic [1:0] cfg_mode = '0;
  logic [7:0] cfg_div = 8'd2, cfg_frames = '0;
  logic [15:0] tx_data = '0, rx_data;
  logic busy, tx_full, rx_empty, sclk, ss_n, mosi;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_xfer_engine u0 (.*);

  // bench-side bus monitor: rebuilds frames from mosi at the R3 sample edges
  logic [63:0] mon = '0;
  int mbits = 0, since = 0, gap = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (!ss_n) begin
      if (sclk != sclk_prev) begin
        gap   <= since;
        since <= 1;
        if (cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol)) begin
          mon   <= {mon[62:0], mosi};
          mbits <= mbits + 1;
        end
      end else since <= since + 1;
    end
    sclk_prev <= sclk;
  end

  typedef struct packed {
    logic [3:0]  fs;
    logic        cpha;
    logic        cpol;
    logic [7:0]  div;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd7,  1'b0, 1'b0, 8'd2,  16'h00A5},
    '{4'd7,  1'b1, 1'b0, 8'd4,  16'h003C},
    '{4'd15, 1'b0, 1'b1, 8'd6,  16'hBEEF},
    '{4'd15, 1'b1, 1'b1, 8'd2,  16'h1234},
    '{4'd3,  1'b0, 1'b0, 8'd8,  16'hFFF9},
    '{4'd0,  1'b1, 1'b0, 8'd2,  16'h0001},
    '{4'd11, 1'b1, 1'b1, 8'd4,  16'hF5A3},
    '{4'd4,  1'b0, 1'b1, 8'd10, 16'h0016}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] low_ones(input int fs);
    logic [15:0] m = '0;
    for (int i = 0; i <= fs; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic push_word(input logic [15:0] w);
    tx_data = w; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop_word(output logic [15:0] w);
    w = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  int base;
  task automatic run_xfer();
    base = mbits;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R4 idle clock level
    check(ss_n == 1'b1 && busy == 1'b0, "R11 reset select/busy", {ss_n, busy}, 2'b10);
    check(rx_empty == 1'b1, "R11 reset rx empty", rx_empty, 1);
    check(sclk == cfg_cpol, "R4 reset sclk level", sclk, cfg_cpol);

    // table-driven single-frame duplex transfers in loopback
    cfg_loop = 1'b1; cfg_mode = 2'b00;
    for (int v = 0; v < 8; v++) begin
      cfg_frame_size = VEC[v].fs; cfg_cpha = VEC[v].cpha;
      cfg_cpol = VEC[v].cpol; cfg_div = VEC[v].div;
      @(negedge clk);
      exp = VEC[v].word & low_ones(int'(VEC[v].fs));
      push_word(VEC[v].word);
      run_xfer();
      check(mbits - base == int'(VEC[v].fs) + 1, "R1 bits per frame", mbits - base, int'(VEC[v].fs) + 1);
      check((mon[15:0] & low_ones(int'(VEC[v].fs))) == exp, "R3 mosi at sample edges", mon[15:0], exp);
      check(gap == int'(VEC[v].div) / 2, "R5 half period", gap, int'(VEC[v].div) / 2);
      check(sclk == cfg_cpol && ss_n, "R4 sclk idle after transfer", sclk, cfg_cpol);
      pop_word(w);
      check(w == exp, "R2 R10 right-justified loopback word", w, exp);
      check(rx_empty == 1'b1, "R6 one frame stored", rx_empty, 1);
    end

    // R10 / R2: external miso held high, no loopback
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd2; cfg_frame_size = 4'd5;
    cfg_loop = 1'b0; miso = 1'b1;
    push_word(16'h0000);
    run_xfer();
    pop_word(w);
    check(w == 16'h003F, "R10 miso used, R2 zero pad", w, 16'h003F);
    // R10: loopback ignores miso
    cfg_loop = 1'b1;
    push_word(16'h0000);
    run_xfer();
    pop_word(w);
    check(w == 16'h0000, "R10 loopback ignores miso", w, 0);

    // R6: three words in duplex mode
    cfg_frame_size = 4'd7; miso = 1'b0;
    push_word(16'h0011); push_word(16'h0022); push_word(16'h0033);
    run_xfer();
    check(mbits - base == 24, "R6 all words sent", mbits - base, 24);
    pop_word(w); check(w == 16'h0011, "R6 rx word 0", w, 16'h11);
    pop_word(w); check(w == 16'h0022, "R6 rx word 1", w, 16'h22);
    pop_word(w); check(w == 16'h0033, "R6 rx word 2", w, 16'h33);
    check(rx_empty == 1'b1, "R6 rx drained", rx_empty, 1);

    // R7: send-only stores nothing
    cfg_mode = 2'b01;
    push_word(16'h00C3); push_word(16'h003C);
    run_xfer();
    check(mon[15:0] == 16'hC33C, "R7 words sent", mon[15:0], 16'hC33C);
    check(rx_empty == 1'b1, "R7 nothing stored", rx_empty, 1);

    // R8: receive-only repeats one word for frames+1 frames
    cfg_mode = 2'b10; cfg_frames = 8'd2;
    push_word(16'h005A);
    run_xfer();
    check(mbits - base == 24, "R8 frame count", mbits - base, 24);
    check(mon[23:0] == 24'h5A5A5A, "R8 word repeated", mon[23:0], 24'h5A5A5A);
    for (int k = 0; k < 3; k++) begin
      pop_word(w);
      check(w == 16'h005A, "R8 stored frame", w, 16'h5A);
    end
    check(rx_empty == 1'b1, "R8 exact store count", rx_empty, 1);

    // R9: command then read, data from miso
    cfg_mode = 2'b11; cfg_frames = 8'd1; cfg_loop = 1'b0; miso = 1'b1;
    push_word(16'h00C1); push_word(16'h00C2);
    run_xfer();
    check(mbits - base == 32, "R9 total frames", mbits - base, 32);
    check(mon[31:0] == 32'hC1C2_0000, "R9 commands then low mosi", mon[31:0], 32'hC1C20000);
    pop_word(w); check(w == 16'h00FF, "R9 read frame 0", w, 16'hFF);
    pop_word(w); check(w == 16'h00FF, "R9 read frame 1", w, 16'hFF);
    check(rx_empty == 1'b1, "R9 commands not stored", rx_empty, 1);

    // R11: start during a transfer has no effect
    cfg_mode = 2'b00; cfg_loop = 1'b1; miso = 1'b0; cfg_div = 8'd8; cfg_frame_size = 4'd15;
    push_word(16'h8001);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy && !ss_n, "R11 busy and select held mid-transfer", {busy, ss_n}, 2'b10);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!busy && ss_n, "R11 no restart from repeated start", {busy, ss_n}, 2'b01);
    pop_word(w);
    check(w == 16'h8001, "R11 single frame word", w, 16'h8001);
    check(rx_empty == 1'b1, "R11 single frame stored", rx_empty, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule